// File: doc/BRIEF.md
# Fault Class Reporting and Recovery Controller

This block collects synchronous condition bits from a set of protection detectors and turns them into a sticky status word, an active-low fault line and a power-good line. Each source is given a class at elaboration time. The class decides three things: whether the fault line is held low or toggles, what clears the status bit, and which recovery action applies.

Latched classes hold the fault line low until a recovery happens. A recovery is a rising edge on the gate-enable input or a write of 1 to the self-clearing clear bit. Warning and report-only classes make the fault line toggle with a square wave. A read of the status word acknowledges them. Real-time sources only mirror their live condition in the status word. The latched-with-power-good class also pulls the power-good line low for a minimum hold time.

The serial interface is not part of this block. It is represented by a status-read strobe and by a write strobe with a data bit for the clear control.

Top module: `fault_recovery_ctrl`

## Requirements
- R1: After reset, every status bit is 0, `clr_o` is 0, and both `fault_n_o` and `pgood_o` are 1.
- R2: For a latched or latched-with-power-good source, the status bit sets in the cycle after its condition is seen and stays set after the condition ends. While any such bit is set, `fault_n_o` is 0.
- R3: A 0-to-1 transition of `gate_en_i` is a recovery. The latched status bits clear in the following cycle, except that a bit whose condition is still present stays set. With no latched bit left, `fault_n_o` is released.
- R4: A cycle with `clr_wr_i`=1 and `clr_data_i`=1 sets `clr_o` for exactly one cycle. That cycle acts as a recovery in the same way as R3, and `clr_o` then returns to 0 by itself. A write with `clr_data_i`=0 does nothing.
- R5: While any warning or report-only status bit is set and no latched bit is set, `fault_n_o` toggles. It starts low the cycle after the bit sets and stays low for HALF_CYC cycles, then high for HALF_CYC cycles, and so on. The full period is 2*HALF_CYC cycles, where HALF_CYC is the number of clock cycles in 32 µs.
- R6: A pulse on `stat_rd_i` clears the warning and report-only status bits whose condition is absent in that cycle. A bit whose condition is still present stays set and toggling continues. Once no such bit remains, `fault_n_o` returns to 1.
- R7: A real-time status bit equals its condition delayed by one cycle and never changes `fault_n_o`.
- R8: A set latched bit takes priority over toggling. `fault_n_o` stays solidly 0 even while a warning bit is set.
- R9: When a latched-with-power-good bit sets, `pgood_o` goes to 0. It stays 0 while that bit is set, and for at least 2*HALF_CYC cycles after the set, even if recovery comes sooner.
- R10: A recovery does not clear warning, report-only or real-time bits. A status read does not clear latched bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | N_SRC | Live condition bit per source |
| gate_en_i | input | 1 | Gate enable; rising edge is a recovery |
| stat_rd_i | input | 1 | Status-word read strobe |
| clr_wr_i | input | 1 | Write strobe for the clear control |
| clr_data_i | input | 1 | Clear bit value written |
| status_o | output | N_SRC | Sticky status word |
| clr_o | output | 1 | Clear control read-back, self-clearing |
| fault_n_o | output | 1 | Active-low fault indication |
| pgood_o | output | 1 | Power-good, low on power-good class fault |

## Verification
Each class is driven on its own with short pulses and with held conditions. A pulse shows a sticky bit apart from a live one. A held condition shows whether a read or a recovery wrongly drops a bit whose cause is still present. Warning and latched sources are then overlapped to expose the priority of solid low over toggling. A power-good fault followed at once by a clear separates the minimum power-good hold from the status-bit lifetime. The clear is applied both through the clear bit and through a gate-enable edge, to show that both paths affect only the latched bits.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [2:0] {
        FR_LATCH    = 3'd0,
        FR_WARN     = 3'd1,
        FR_REPORT   = 3'd2,
        FR_RTIME    = 3'd3,
        FR_LATCH_PG = 3'd4
    } fr_class_e;

    localparam int FR_CLS_W = 3;

    function automatic logic cls_is_latched(input logic [2:0] c);
        return (c == FR_LATCH) || (c == FR_LATCH_PG);
    endfunction

    function automatic logic cls_is_warn(input logic [2:0] c);
        return (c == FR_WARN) || (c == FR_REPORT);
    endfunction

endpackage

// File: rtl/fr_src_bit.sv
module fr_src_bit
    import fr_pkg::*;
#(
    parameter fr_class_e CLS = FR_LATCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic recover_i,
    input  logic rd_i,
    output logic st_o
);

    logic st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (CLS)
            FR_LATCH, FR_LATCH_PG: st_d = cond_i | (st_q & ~recover_i);
            FR_WARN, FR_REPORT:    st_d = cond_i | (st_q & ~rd_i);
            default:               st_d = cond_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/fr_toggle.sv
module fr_toggle #(
    parameter int HALF_CYC = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic phase_o
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } tog_t;

    tog_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.cnt   = '0;
            r_d.phase = 1'b0;
        end else if (r_q.cnt == LAST) begin
            r_d.cnt   = '0;
            r_d.phase = ~r_q.phase;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign phase_o = r_q.phase;

endmodule

// File: rtl/fr_pg_hold.sv
module fr_pg_hold #(
    parameter int HOLD_CYC = 6400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic hold_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = HW'(HOLD_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hold_o = (cnt_q != '0);

endmodule

// File: rtl/fault_recovery_ctrl.sv
module fault_recovery_ctrl
    import fr_pkg::*;
#(
    parameter int                    N_SRC     = 6,
    parameter int                    HALF_CYC  = 3200,
    parameter logic [3*N_SRC-1:0]    SRC_CLASS = {3'd1, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cond_i,
    input  logic             gate_en_i,
    input  logic             stat_rd_i,
    input  logic             clr_wr_i,
    input  logic             clr_data_i,
    output logic [N_SRC-1:0] status_o,
    output logic             clr_o,
    output logic             fault_n_o,
    output logic             pgood_o
);

    localparam int HOLD_CYC = 2 * HALF_CYC;

    typedef struct packed {
        logic gate;
        logic clr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [N_SRC-1:0] st;
    logic [N_SRC-1:0] lat_m, warn_m, pg_m;
    logic             recover;
    logic             lat_any, warn_any, pg_any;
    logic             pg_start, phase, pg_hold;

    assign recover = c_q.clr | (gate_en_i & ~c_q.gate);

    always_comb begin
        c_d      = c_q;
        c_d.gate = gate_en_i;
        c_d.clr  = clr_wr_i & clr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam fr_class_e CLS = fr_class_e'(SRC_CLASS[FR_CLS_W*g +: FR_CLS_W]);
        assign lat_m[g]  = cls_is_latched(CLS);
        assign warn_m[g] = cls_is_warn(CLS);
        assign pg_m[g]   = (CLS == FR_LATCH_PG);
        fr_src_bit #(.CLS(CLS)) u_bit (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond_i    (cond_i[g]),
            .recover_i (recover),
            .rd_i      (stat_rd_i),
            .st_o      (st[g])
        );
    end

    assign lat_any  = |(st & lat_m);
    assign warn_any = |(st & warn_m);
    assign pg_any   = |(st & pg_m);
    assign pg_start = (|(cond_i & pg_m)) & ~pg_any;

    fr_toggle #(.HALF_CYC(HALF_CYC)) u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (warn_any),
        .phase_o (phase)
    );

    fr_pg_hold #(.HOLD_CYC(HOLD_CYC)) u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pg_start),
        .hold_o  (pg_hold)
    );

    assign status_o  = st;
    assign clr_o     = c_q.clr;
    assign fault_n_o = ~(lat_any | (warn_any & ~phase));
    assign pgood_o   = ~(pg_any | pg_hold);

endmodule

// File: rtl/fr_ctrl_chk.sv
module fr_ctrl_chk
    import fr_pkg::*;
#(
    parameter int                 N_SRC     = 6,
    parameter logic [3*N_SRC-1:0] SRC_CLASS = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] cond_i,
    input logic             stat_rd_i,
    input logic [N_SRC-1:0] status_o,
    input logic             clr_o,
    input logic             fault_n_o,
    input logic             pgood_o
);

    logic [N_SRC-1:0] lat_m, warn_m, rt_m, pg_m;

    for (genvar g = 0; g < N_SRC; g++) begin : g_m
        localparam logic [2:0] C = SRC_CLASS[3*g +: 3];
        assign lat_m[g]  = cls_is_latched(C);
        assign warn_m[g] = cls_is_warn(C);
        assign rt_m[g]   = (C == FR_RTIME);
        assign pg_m[g]   = (C == FR_LATCH_PG);
    end

    p_latch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & lat_m) != '0) |-> !fault_n_o);

    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> ((status_o & lat_m & ~$past(cond_i)) == '0));

    p_quiet_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & (lat_m | warn_m)) == '0) |-> fault_n_o);

    p_read_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> ((status_o & warn_m & ~$past(cond_i)) == '0));

    p_rt_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & rt_m) == ($past(cond_i) & rt_m)));

    p_pg_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & pg_m) != '0) |-> !pgood_o);

endmodule

bind fault_recovery_ctrl fr_ctrl_chk #(.N_SRC(N_SRC), .SRC_CLASS(SRC_CLASS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .stat_rd_i (stat_rd_i),
    .status_o  (status_o),
    .clr_o     (clr_o),
    .fault_n_o (fault_n_o),
    .pgood_o   (pgood_o)
);

// File: tb/fault_recovery_ctrl_test.sv
module fault_recovery_ctrl_test;

    localparam int N = 6;
    localparam int H = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cond = '0;
    logic         gate_en = 1'b0, rd = 1'b0, clr_wr = 1'b0, clr_data = 1'b0;
    logic [N-1:0] status;
    logic         clr_o, fault_n, pgood;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    // classes: 0 latched, 1 warning, 2 report-only, 3 real-time, 4 latched+power-good
    int cls [N] = '{0, 1, 2, 3, 4, 1};

    always #5 clk = ~clk;

    fault_recovery_ctrl #(
        .N_SRC(N), .HALF_CYC(H),
        .SRC_CLASS({3'd1, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0})
    ) uut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .gate_en_i(gate_en),
        .stat_rd_i(rd), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
        .status_o(status), .clr_o(clr_o), .fault_n_o(fault_n), .pgood_o(pgood)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_st [N];
    bit  m_gate, m_clr, m_phase;
    int  m_tcnt, m_pgcnt;

    function automatic bit any_of(input int kind);
        for (int i = 0; i < N; i++) begin
            if (m_st[i] != 0) begin
                if (kind == 0 && (cls[i] == 0 || cls[i] == 4)) return 1;
                if (kind == 1 && (cls[i] == 1 || cls[i] == 2)) return 1;
                if (kind == 2 && cls[i] == 4) return 1;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_st[i] = 0;
            m_gate = 0; m_clr = 0; m_phase = 0; m_tcnt = 0; m_pgcnt = 0;
        end else begin
            bit rec, w_any, p_any, pg_cond;
            rec     = m_clr || (gate_en && !m_gate);
            w_any   = any_of(1);
            p_any   = any_of(2);
            pg_cond = 0;
            for (int i = 0; i < N; i++) begin
                if (cls[i] == 4 && cond[i]) pg_cond = 1;
                case (cls[i])
                    0, 4:    m_st[i] = (cond[i] || (m_st[i] != 0 && !rec)) ? 1 : 0;
                    1, 2:    m_st[i] = (cond[i] || (m_st[i] != 0 && !rd)) ? 1 : 0;
                    default: m_st[i] = cond[i] ? 1 : 0;
                endcase
            end
            if (!w_any) begin
                m_tcnt = 0; m_phase = 0;
            end else if (m_tcnt == H - 1) begin
                m_tcnt = 0; m_phase = !m_phase;
            end else begin
                m_tcnt++;
            end
            if (pg_cond && !p_any) m_pgcnt = 2 * H;
            else if (m_pgcnt > 0)  m_pgcnt--;
            m_clr  = clr_wr && clr_data;
            m_gate = gate_en;
        end
        #1;
        if (rst_n) begin
            int exp_st;
            int exp_fn;
            exp_st = 0;
            for (int i = 0; i < N; i++) exp_st |= (m_st[i] << i);
            exp_fn = any_of(0) ? 0 : (any_of(1) ? int'(m_phase) : 1);
            chk({cur_req, " status"}, int'(status), exp_st);
            chk({cur_req, " fault_n"}, int'(fault_n), exp_fn);
            chk({cur_req, " pgood"}, int'(pgood), (any_of(2) || m_pgcnt > 0) ? 0 : 1);
            chk({cur_req, " clr"}, int'(clr_o), int'(m_clr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd;
        rd = 1'b1; cyc(1); rd = 1'b0;
    endtask

    task automatic write_clr(input logic v);
        clr_wr = 1'b1; clr_data = v; cyc(1); clr_wr = 1'b0; clr_data = 1'b0;
    endtask

    task automatic gate_toggle;
        gate_en = 1'b0; cyc(2); gate_en = 1'b1; cyc(1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 fault_n", int'(fault_n), 1);
        chk("R1 pgood", int'(pgood), 1);
        chk("R1 clr", int'(clr_o), 0);
        gate_en = 1'b1; cyc(2);

        // R2 latched sticky
        cur_req = "R2";
        cond[0] = 1'b1; cyc(2); cond[0] = 1'b0; cyc(3);
        chk("R2 latched bit", int'(status[0]), 1);
        chk("R2 fault low", int'(fault_n), 0);

        // R10 read leaves latched bit
        cur_req = "R10";
        pulse_rd(); cyc(2);
        chk("R10 read keeps latched", int'(status[0]), 1);

        // R3 gate-enable edge recovery
        cur_req = "R3";
        gate_toggle(); cyc(1);
        chk("R3 latched cleared", int'(status[0]), 0);
        chk("R3 fault released", int'(fault_n), 1);
        cond[0] = 1'b1; cyc(2);
        gate_toggle(); cyc(1);
        chk("R3 present condition stays", int'(status[0]), 1);
        cond[0] = 1'b0; cyc(2);

        // R4 clear bit
        cur_req = "R4";
        write_clr(1'b0); cyc(1);
        chk("R4 zero write ignored", int'(status[0]), 1);
        clr_wr = 1'b1; clr_data = 1'b1; cyc(1);
        clr_wr = 1'b0; clr_data = 1'b0;
        chk("R4 clr reads one", int'(clr_o), 1);
        cyc(1);
        chk("R4 clr self clears", int'(clr_o), 0);
        chk("R4 latched cleared", int'(status[0]), 0);
        chk("R4 fault released", int'(fault_n), 1);

        // R5 warning toggling
        cur_req = "R5";
        cond[1] = 1'b1; cyc(1); cond[1] = 1'b0;
        chk("R5 low after set", int'(fault_n), 0);
        begin
            int falls = 0;
            logic prev = fault_n;
            for (int k = 0; k < 4 * H; k++) begin
                cyc(1);
                if (prev && !fault_n) falls++;
                prev = fault_n;
            end
            chk("R5 toggles repeat", (falls >= 1) ? 1 : 0, 1);
        end

        // R6 read acknowledge
        cur_req = "R6";
        pulse_rd(); cyc(2);
        chk("R6 warn cleared", int'(status[1]), 0);
        chk("R6 fault high", int'(fault_n), 1);
        cond[5] = 1'b1; cyc(3); pulse_rd(); cyc(2);
        chk("R6 present warn stays", int'(status[5]), 1);
        cond[5] = 1'b0; cyc(1); pulse_rd(); cyc(1);
        chk("R6 warn cleared late", int'(status[5]), 0);
        cur_req = "R5";
        cond[2] = 1'b1; cyc(1); cond[2] = 1'b0;
        chk("R5 report-only low", int'(fault_n), 0);
        cyc(2 * H); pulse_rd(); cyc(1);
        chk("R6 report-only cleared", int'(status[2]), 0);

        // R7 real-time
        cur_req = "R7";
        cond[3] = 1'b1; cyc(1);
        chk("R7 follows", int'(status[3]), 1);
        chk("R7 no fault", int'(fault_n), 1);
        cyc(2); cond[3] = 1'b0; cyc(1);
        chk("R7 drops", int'(status[3]), 0);

        // R8 latched priority
        cur_req = "R8";
        cond[1] = 1'b1; cyc(1); cond[1] = 1'b0;
        cond[0] = 1'b1; cyc(1); cond[0] = 1'b0; cyc(1);
        begin
            int highs = 0;
            for (int k = 0; k < 3 * H; k++) begin
                if (fault_n) highs++;
                cyc(1);
            end
            chk("R8 solid low", highs, 0);
        end
        cur_req = "R10";
        write_clr(1'b1); cyc(1);
        chk("R10 recovery keeps warn", int'(status[1]), 1);
        pulse_rd(); cyc(2);

        // R9 power-good hold
        cur_req = "R9";
        cond[4] = 1'b1; cyc(1); cond[4] = 1'b0;
        chk("R9 pgood low", int'(pgood), 0);
        write_clr(1'b1); cyc(2);
        chk("R9 bit cleared", int'(status[4]), 0);
        chk("R9 pgood held", int'(pgood), 0);
        cyc(2 * H + 2);
        chk("R9 pgood restored", int'(pgood), 1);

        cyc(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule